// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This block drives a single open-drain 1-Wire line on behalf of a simple command port. The host raises `start` for one clock together with a command code. The engine then produces the timed low pulses on the line, samples the line at fixed points, and reports the outcome. It supports four commands: a bus reset with presence detection, a single-bit touch, a byte write and a byte read.

Every duration is a whole number of microseconds. The microsecond base comes from a clock divider set by `CLK_PER_US`, and the divider restarts when a command is accepted. Each phase therefore lasts exactly its microsecond count times `CLK_PER_US` clock cycles. A read uses the same slot as a write of a one, with the line level captured. A byte read is a byte write of 0xFF whose sampled bits are returned.

The line input passes through a `SYNC_STAGES`-deep synchronizer. The level that counts at a sample point is the one present on `ow_in` during the `SYNC_STAGES` clock cycles before that point.

Top module: `owire_master`

## Requirements
- R1: After a reset command (cmd 2'b00) is accepted, `ow_oe` is high for exactly 480 microseconds (480·CLK_PER_US cycles) starting the cycle after acceptance, then stays low until the command ends.
- R2: The line is sampled 70 µs after the reset pulse is released, and the command completes 410 µs after that, 960 µs in total. `presence_n` becomes 0 if the sampled line was low (a device answered) and 1 if it was high.
- R3: Every bit slot lasts 70 µs. `ow_oe` is high for the first 6 µs of a slot that sends a one and for the first 60 µs of a slot that sends a zero, and slots follow each other with no gap.
- R4: A touch command (cmd 2'b01) runs one slot that sends `wr_data[0]`. The line is sampled 15 µs after the slot starts. `rd_data` becomes {7'b0, sampled level}, and touching with 0 always returns 0.
- R5: A write-byte command (cmd 2'b10) sends `wr_data` as eight slots, least-significant bit first. A read-byte command (cmd 2'b11) sends 0xFF the same way. In both cases, bit i of `rd_data` is the level sampled in slot i.
- R6: `busy` is high from the cycle after a command is accepted until the cycle in which it completes. In that completion cycle `busy` is low and `done` is high for exactly that one cycle. `ow_oe` is low whenever `busy` is low.
- R7: `presence_n` changes only when a reset command completes, and `rd_data` changes only when a touch or byte command completes. Both hold their value in between.
- R8: A `start` pulse while `busy` is high is ignored: the running command's line waveform, timing and result are unchanged.
- R9: After reset, `busy`, `done` and `ow_oe` are 0, `rd_data` is 0x00 and `presence_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe, honoured only while idle |
| cmd | input | 2 | Command: 00 reset, 01 touch, 10 write byte, 11 read byte |
| wr_data | input | 8 | Byte to send, or bit 0 for a touch |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Sampled bits of the last touch or byte command |
| presence_n | output | 1 | Result of the last reset, 0 when a device answered |
| ow_in | input | 1 | Level seen on the 1-Wire line |
| ow_oe | output | 1 | Pull the line low when high |

## Verification
The assertions assume that `start` is low while `rst` is high and that `ow_in` is whatever the shared line carries, possibly pulled low by devices at any time. They make no timing assumption about that line. The bench models the line as the wired-AND of `ow_oe` and a device model. The device pulls the line low only in windows well clear of each sample point, so the synchronizer delay never makes a sampled bit ambiguous. The host model raises `start` only while the engine is idle, except for one deliberate pulse during a byte read. That pulse tests that the engine ignores it.

// File: rtl/owm_pkg.sv
package owm_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'b00,
      OP_TOUCH = 2'b01,
      OP_WRITE = 2'b10,
      OP_READ  = 2'b11
   } owm_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RLOW,
      ST_RPRES,
      ST_RTAIL,
      ST_SLOT
   } owm_state_e;

   function automatic int owm_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/owm_usdiv.sv
// Microsecond tick generator; restarted on command acceptance so that each
// phase spans an exact multiple of CLK_PER_US cycles.
module owm_usdiv #(
   parameter int CLK_PER_US = 50
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);

   generate
      if (CLK_PER_US == 1) begin : g_pass
         logic unused_pass;
         assign unused_pass = clk ^ rst ^ restart;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_PER_US);
         localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);
         logic [DW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst || restart)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/owm_sync.sv
// Line-input synchronizer; STAGES = 0 selects a direct pass-through.
module owm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         logic unused_direct;
         assign unused_direct = clk ^ rst;
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= (sh << 1) | STAGES'(d);
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/owm_seq.sv
// Command sequencer: reset/presence phases and bit slots.
module owm_seq
   import owm_pkg::*;
#(
   parameter int T_RST_LOW   = 480,
   parameter int T_PRES_WAIT = 70,
   parameter int T_RST_TAIL  = 410,
   parameter int T_SLOT      = 70,
   parameter int T_W1_LOW    = 6,
   parameter int T_W0_LOW    = 60,
   parameter int T_SAMPLE    = 15,
   parameter int UW          = 9
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [1:0] cmd,
   input  logic [7:0] wr_data,
   input  logic       tick,
   input  logic       line_s,
   output logic       restart,
   output logic       ow_oe,
   output logic       busy,
   output logic       done,
   output logic [7:0] rd_data,
   output logic       presence_n
);

   localparam logic [UW-1:0] L_RLOW  = UW'(T_RST_LOW - 1);
   localparam logic [UW-1:0] L_PRES  = UW'(T_PRES_WAIT - 1);
   localparam logic [UW-1:0] L_TAIL  = UW'(T_RST_TAIL - 1);
   localparam logic [UW-1:0] L_SLOT  = UW'(T_SLOT - 1);
   localparam logic [UW-1:0] L_SAMP  = UW'(T_SAMPLE - 1);
   localparam logic [UW-1:0] W1_LEN  = UW'(T_W1_LOW);
   localparam logic [UW-1:0] W0_LEN  = UW'(T_W0_LOW);

   owm_state_e    state;
   owm_op_e       op;
   logic [UW-1:0] us;
   logic [7:0]    tx;
   logic [7:0]    rx;
   logic [2:0]    idx;
   logic          pres_s;
   logic [UW-1:0] last;
   logic [7:0]    first_tx;
   logic          phase_end;
   logic          samp_now;
   logic          final_slot;

   always_comb begin
      case (state)
         ST_RLOW:  last = L_RLOW;
         ST_RPRES: last = L_PRES;
         ST_RTAIL: last = L_TAIL;
         default:  last = L_SLOT;
      endcase
   end

   always_comb begin
      case (owm_op_e'(cmd))
         OP_READ:  first_tx = 8'hFF;
         OP_TOUCH: first_tx = {7'b0, wr_data[0]};
         default:  first_tx = wr_data;
      endcase
   end

   assign phase_end  = tick && (us == last);
   assign samp_now   = (state == ST_SLOT) && tick && (us == L_SAMP);
   assign final_slot = (op == OP_TOUCH) || (idx == 3'd7);
   assign restart    = (state == ST_IDLE) && start;
   assign busy       = (state != ST_IDLE);
   assign ow_oe      = (state == ST_RLOW) ||
                       ((state == ST_SLOT) && (us < (tx[0] ? W1_LEN : W0_LEN)));

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         op         <= OP_RESET;
         us         <= '0;
         tx         <= '0;
         rx         <= '0;
         idx        <= '0;
         pres_s     <= 1'b1;
         done       <= 1'b0;
         rd_data    <= '0;
         presence_n <= 1'b1;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            if (start) begin
               op    <= owm_op_e'(cmd);
               us    <= '0;
               idx   <= '0;
               tx    <= first_tx;
               state <= (owm_op_e'(cmd) == OP_RESET) ? ST_RLOW : ST_SLOT;
            end
         end else if (tick) begin
            us <= us + 1'b1;
            if (samp_now) rx <= {line_s & tx[0], rx[7:1]};
            if (phase_end) begin
               us <= '0;
               case (state)
                  ST_RLOW:  state <= ST_RPRES;
                  ST_RPRES: begin
                     pres_s <= line_s;
                     state  <= ST_RTAIL;
                  end
                  ST_RTAIL: begin
                     presence_n <= pres_s;
                     done       <= 1'b1;
                     state      <= ST_IDLE;
                  end
                  default: begin
                     if (final_slot) begin
                        rd_data <= (op == OP_TOUCH) ? {7'b0, rx[7]} : rx;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                     end else begin
                        idx <= idx + 1'b1;
                        tx  <= tx >> 1;
                     end
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/owire_master.sv
module owire_master
   import owm_pkg::*;
#(
   parameter int CLK_PER_US  = 50,
   parameter int T_RST_LOW   = 480,
   parameter int T_PRES_WAIT = 70,
   parameter int T_RST_TAIL  = 410,
   parameter int T_SLOT      = 70,
   parameter int T_W1_LOW    = 6,
   parameter int T_W0_LOW    = 60,
   parameter int T_SAMPLE    = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [1:0] cmd,
   input  logic [7:0] wr_data,
   output logic       busy,
   output logic       done,
   output logic [7:0] rd_data,
   output logic       presence_n,
   input  logic       ow_in,
   output logic       ow_oe
);

   localparam int T_MAX = owm_max4(T_RST_LOW, T_PRES_WAIT, T_RST_TAIL, T_SLOT);
   localparam int UW    = (T_MAX > 1) ? $clog2(T_MAX) : 1;

   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("CLK_PER_US must be at least 1");
      end
      if (!((T_W1_LOW > 0) && (T_W1_LOW < T_SAMPLE) && (T_SAMPLE < T_W0_LOW) &&
            (T_W0_LOW < T_SLOT))) begin : g_bad_slot
         $error("slot timing must satisfy 0 < T_W1_LOW < T_SAMPLE < T_W0_LOW < T_SLOT");
      end
      if ((T_RST_LOW < 1) || (T_PRES_WAIT < 1) || (T_RST_TAIL < 1)) begin : g_bad_rst
         $error("reset phases must be at least one microsecond");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic tick;
   logic restart;
   logic line_s;

   owm_usdiv #(.CLK_PER_US(CLK_PER_US)) u_div (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .tick    (tick)
   );

   owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (ow_in),
      .q   (line_s)
   );

   owm_seq #(
      .T_RST_LOW   (T_RST_LOW),
      .T_PRES_WAIT (T_PRES_WAIT),
      .T_RST_TAIL  (T_RST_TAIL),
      .T_SLOT      (T_SLOT),
      .T_W1_LOW    (T_W1_LOW),
      .T_W0_LOW    (T_W0_LOW),
      .T_SAMPLE    (T_SAMPLE),
      .UW          (UW)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .cmd        (cmd),
      .wr_data    (wr_data),
      .tick       (tick),
      .line_s     (line_s),
      .restart    (restart),
      .ow_oe      (ow_oe),
      .busy       (busy),
      .done       (done),
      .rd_data    (rd_data),
      .presence_n (presence_n)
   );

endmodule

// File: rtl/owire_master_chk.sv
module owire_master_chk #(
   parameter int LIMIT = 24000
) (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       ow_oe,
   input logic       presence_n,
   input logic [7:0] rd_data
);

   // Length of the current drive-low run, in cycles.
   logic [31:0] oe_run;
   always_ff @(posedge clk) begin
      if (rst)        oe_run <= '0;
      else if (ow_oe) oe_run <= oe_run + 1'b1;
      else            oe_run <= '0;
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start));

   a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !ow_oe);

   a_r7_presence_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(presence_n) |-> done);

   a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(rd_data) |-> done);

   a_r1_low_bounded: assert property (@(posedge clk) disable iff (rst)
      oe_run <= 32'(LIMIT));

endmodule

bind owire_master owire_master_chk #(.LIMIT(T_RST_LOW * CLK_PER_US)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .ow_oe      (ow_oe),
   .presence_n (presence_n),
   .rd_data    (rd_data)
);

// File: tb/owire_master_test.sv
module owire_master_test;

   localparam int CLK_PERIOD = 10;
   localparam int CPU        = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [1:0] cmd = 2'b00;
   logic [7:0] wr_data = 8'h00;
   logic       busy, done, presence_n, ow_oe, ow_in;
   logic [7:0] rd_data;

   int n_tests = 0;
   int n_fail  = 0;

   // device model state
   int       sl_mode = 0;       // 0 silent, 1 answer reset, 2 answer slots
   bit       sl_present = 1'b0;
   logic [7:0] sl_byte = 8'hFF;
   int       sl_idx = 0;
   int       sl_t = 0;
   bit       sl_armed = 1'b0;
   bit       sl_bit = 1'b1;
   logic     sl_pull = 1'b0;
   logic     oe_q = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign ow_in = ~(ow_oe | sl_pull);

   owire_master #(.CLK_PER_US(CPU)) uut (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .cmd        (cmd),
      .wr_data    (wr_data),
      .busy       (busy),
      .done       (done),
      .rd_data    (rd_data),
      .presence_n (presence_n),
      .ow_in      (ow_in),
      .ow_oe      (ow_oe)
   );

   always @(negedge clk) begin
      sl_t = sl_t + 1;
      if (sl_mode == 1 && oe_q && !ow_oe) begin
         sl_t = 0;
         sl_armed = 1'b1;
      end
      if (sl_mode == 2 && !oe_q && ow_oe) begin
         sl_t = 0;
         sl_bit = sl_byte[sl_idx % 8];
         sl_idx = sl_idx + 1;
         sl_armed = 1'b1;
      end
      if (sl_mode == 1)
         sl_pull = sl_armed && sl_present && (sl_t >= 20*CPU) && (sl_t < 150*CPU);
      else if (sl_mode == 2)
         sl_pull = sl_armed && !sl_bit && (sl_t < 30*CPU);
      else
         sl_pull = 1'b0;
      oe_q = ow_oe;
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // Issue a command and compare the reference waveform on every clock.
   task automatic run_cmd(input logic [1:0] c, input logic [7:0] d, input int mode,
                          input bit present, input logic [7:0] sbyte, input int poke,
                          input string rtag);
      bit q[$];
      logic [7:0] txb;
      int nb, total, e_oe, e_busy, e_done, first_oe;
      q.delete();
      sl_mode = mode; sl_present = present; sl_byte = sbyte;
      sl_idx = 0; sl_armed = 1'b0;
      if (c == 2'b00) begin
         for (int i = 0; i < 480*CPU; i++) q.push_back(1'b1);
         for (int i = 0; i < 480*CPU; i++) q.push_back(1'b0);
      end else begin
         nb  = (c == 2'b01) ? 1 : 8;
         txb = (c == 2'b11) ? 8'hFF : (c == 2'b01) ? {7'b0, d[0]} : d;
         for (int k = 0; k < nb; k++)
            for (int i = 0; i < 70*CPU; i++)
               q.push_back(i < (txb[k] ? 6 : 60) * CPU);
      end
      total = q.size();
      @(negedge clk);
      start = 1'b1; cmd = c; wr_data = d;
      @(negedge clk);
      start = 1'b0;
      e_oe = 0; e_busy = 0; e_done = 0; first_oe = -1;
      for (int i = 0; i <= total; i++) begin
         if (i == poke) begin
            start = 1'b1; cmd = 2'b00; wr_data = ~d;
         end else begin
            start = 1'b0;
         end
         if (ow_oe !== ((i < total) ? q[i] : 1'b0)) begin
            e_oe++;
            if (first_oe < 0) first_oe = i;
         end
         if (busy !== (i < total)) e_busy++;
         if (done !== (i == total)) e_done++;
         if (i < total) @(negedge clk);
      end
      start = 1'b0;
      check(e_oe == 0, (c == 2'b00) ? "R1 drive-low waveform mismatches (count/first)" :
                                      "R3 slot waveform mismatches (count/first)", e_oe, 0);
      if (e_oe != 0) $display("  first mismatch at cycle %0d (%s)", first_oe, rtag);
      check(e_busy == 0, "R6 busy mismatches", e_busy, 0);
      check(e_done == 0, "R6 done mismatches", e_done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      check(busy == 1'b0,       "R9 busy after reset", busy, 0);
      check(done == 1'b0,       "R9 done after reset", done, 0);
      check(ow_oe == 1'b0,      "R9 ow_oe after reset", ow_oe, 0);
      check(presence_n == 1'b1, "R9 presence_n after reset", presence_n, 1);
      check(rd_data == 8'h00,   "R9 rd_data after reset", rd_data, 0);

      // R1 R2: reset with a device answering
      run_cmd(2'b00, 8'h00, 1, 1'b1, 8'hFF, -1, "R1");
      check(presence_n == 1'b0, "R2 presence with device", presence_n, 0);
      repeat (20) @(negedge clk);
      check(presence_n == 1'b0 && done == 1'b0, "R7 presence held after done", presence_n, 0);

      // R4 touch
      run_cmd(2'b01, 8'h01, 2, 1'b0, 8'hFF, -1, "R4");
      check(rd_data == 8'h01, "R4 touch 1, line high", rd_data, 1);
      run_cmd(2'b01, 8'h01, 2, 1'b0, 8'hFE, -1, "R4");
      check(rd_data == 8'h00, "R4 touch 1, device pulls low", rd_data, 0);
      run_cmd(2'b01, 8'hFE, 2, 1'b0, 8'hFF, -1, "R4");
      check(rd_data == 8'h00, "R4 touch 0 returns 0", rd_data, 0);
      check(presence_n == 1'b0, "R7 presence unchanged by touch", presence_n, 0);

      // R5 bytes
      run_cmd(2'b10, 8'hA5, 2, 1'b0, 8'hFF, -1, "R5");
      check(rd_data == 8'hA5, "R5 write A5 readback", rd_data, 8'hA5);
      run_cmd(2'b11, 8'h00, 2, 1'b0, 8'h3C, -1, "R5");
      check(rd_data == 8'h3C, "R5 read 3C", rd_data, 8'h3C);
      run_cmd(2'b11, 8'h00, 2, 1'b0, 8'h81, -1, "R5");
      check(rd_data == 8'h81, "R5 read 81 (LSB first)", rd_data, 8'h81);
      run_cmd(2'b10, 8'h5A, 2, 1'b0, 8'h0F, -1, "R5");
      check(rd_data == 8'h0A, "R5 write 5A with device zeros", rd_data, 8'h0A);
      repeat (15) @(negedge clk);
      check(rd_data == 8'h0A, "R7 rd_data held while idle", rd_data, 8'h0A);

      // R2 no device
      run_cmd(2'b00, 8'h00, 1, 1'b0, 8'hFF, -1, "R1");
      check(presence_n == 1'b1, "R2 presence without device", presence_n, 1);
      check(rd_data == 8'h0A, "R7 rd_data unchanged by reset", rd_data, 8'h0A);

      // R8 start while busy
      run_cmd(2'b11, 8'h00, 2, 1'b0, 8'hC3, 1000, "R8");
      check(rd_data == 8'hC3, "R8 result after ignored start", rd_data, 8'hC3);
      check(presence_n == 1'b1, "R8 presence untouched by ignored start", presence_n, 1);

      repeat (5) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule